// File: doc/BRIEF.md
# Branch Trace Record Stack

This block keeps a short history of control-flow transfers for debug. Each time the core reports a taken branch, an interrupt or an exception while recording is switched on, the block stores the source and destination linear addresses of that transfer as one record in a small circular buffer. A top-of-stack pointer always names the newest record. A read port, addressed by entry number, lets a debugger walk the history once recording has been switched off.

Some transfers arrive as a pair. A branch can trap, and an interrupt can land right after a branch. In both cases the core raises a single strobe that carries the branch addresses and also a second address pair. The block writes the branch record in the strobe cycle and the second record in the cycle after, so the two sit next to each other in order. Addresses are cut down according to the execution mode that comes with the event. Debug exceptions never leave a record, so using the debugger does not disturb the history.

Top module: `lbr_stack`

## Requirements
- R1: While `rec_en` is 0, a strobe on `ev_valid` writes no record and leaves `tos` unchanged.
- R2: With `rec_en` at 1, a strobe of kind branch (`ev_kind`=0), interrupt (1) or exception (2) writes exactly one record at entry `tos+1` (modulo DEPTH), and `tos` points to that entry one cycle after the strobe.
- R3: A strobe of kind debug exception (`ev_kind`=3) never writes a record, whatever the state of `rec_en`.
- R4: A branch strobe with `ev_pair`=1 writes the branch pair (`ev_from`/`ev_to`) at `tos+1` in the strobe cycle and the second pair (`ev2_from`/`ev2_to`) at `tos+2` in the following cycle. When `ev_pair`=1 is set on a strobe whose kind is not branch, it is ignored and only one record is written.
- R5: A strobe that arrives in the cycle in which the second record of a pair is being written is dropped.
- R6: In legacy mode (`ev_mode`=0), only the low 32 bits of each address are stored, and the upper 32 bits read as zero.
- R7: In compatibility mode (`ev_mode`=1), the upper 32 bits of each stored address are cleared.
- R8: In full 64-bit mode (`ev_mode`=2 or 3), all 64 bits of both addresses are stored.
- R9: `tos` wraps from DEPTH-1 to 0, and each new record overwrites the oldest entry.
- R10: Reset sets `tos` and every entry to zero.
- R11: `rd_from`/`rd_to` show the entry selected by `rd_idx` in the same cycle.
- R12: The second record of a pair is written even when `rec_en` falls in the cycle after the strobe. The mode used for both records is the one sampled with the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_en | input | 1 | Recording enable |
| ev_valid | input | 1 | Event strobe |
| ev_kind | input | 2 | 0 branch, 1 interrupt, 2 exception, 3 debug exception |
| ev_pair | input | 1 | Branch is followed by a trap or an interrupt; a second record follows |
| ev_mode | input | 2 | 0 legacy, 1 compatibility, 2/3 full 64-bit |
| ev_from | input | 64 | Source address of the event |
| ev_to | input | 64 | Destination address of the event |
| ev2_from | input | 64 | Source address of the second record of a pair |
| ev2_to | input | 64 | Destination address of the second record of a pair |
| tos | output | log2(DEPTH) | Index of the newest record |
| rd_idx | input | log2(DEPTH) | Entry to read |
| rd_from | output | 64 | Stored source address of entry `rd_idx` |
| rd_to | output | 64 | Stored destination address of entry `rd_idx` |

## Verification
The assertions check the pointer on every cycle. They confirm that it only ever holds or moves forward by one, that it stays still while recording is off or the event is a debug exception, and that the second record of a pair follows the strobe in the very next cycle and moves the pointer. What the stored addresses contain can only be seen through the bench's scenarios. These cover truncation in each mode, the order of the two records in a pair, wrap-around overwriting the oldest entry, and the dropped strobe during a pending write, all read back through the read port and compared against a reference model.

// File: rtl/lbr_stack.sv
module lbr_stack #(
  parameter int DEPTH = 4,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rec_en,
  input  logic          ev_valid,
  input  logic [1:0]    ev_kind,
  input  logic          ev_pair,
  input  logic [1:0]    ev_mode,
  input  logic [63:0]   ev_from,
  input  logic [63:0]   ev_to,
  input  logic [63:0]   ev2_from,
  input  logic [63:0]   ev2_to,
  output logic [PW-1:0] tos,
  input  logic [PW-1:0] rd_idx,
  output logic [63:0]   rd_from,
  output logic [63:0]   rd_to
);
  logic [63:0] from_q [DEPTH];
  logic [63:0] to_q   [DEPTH];
  logic        pend;
  logic [63:0] pend_from, pend_to;

  function automatic logic [63:0] clip(input logic [63:0] a, input logic [1:0] mode);
    return mode[1] ? a : {32'd0, a[31:0]};
  endfunction

  wire          take  = ev_valid && rec_en && (ev_kind != 2'd3) && !pend;
  wire          twice = take && (ev_kind == 2'd0) && ev_pair;
  wire [PW-1:0] slot  = tos + 1'b1;

  assign rd_from = from_q[rd_idx];
  assign rd_to   = to_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tos       <= '0;
      pend      <= 1'b0;
      pend_from <= '0;
      pend_to   <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        from_q[i] <= '0;
        to_q[i]   <= '0;
      end
    end else if (pend) begin
      from_q[slot] <= pend_from;
      to_q[slot]   <= pend_to;
      tos          <= slot;
      pend         <= 1'b0;
    end else if (take) begin
      from_q[slot] <= clip(ev_from, ev_mode);
      to_q[slot]   <= clip(ev_to, ev_mode);
      tos          <= slot;
      pend         <= twice;
      pend_from    <= clip(ev2_from, ev_mode);
      pend_to      <= clip(ev2_to, ev_mode);
    end
  end
endmodule

module lbr_stack_chk #(
  parameter int DEPTH = 4,
  localparam int PW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rec_en,
  input logic          ev_valid,
  input logic [1:0]    ev_kind,
  input logic          ev_pair,
  input logic          pend,
  input logic [PW-1:0] tos
);
  AST_TOS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (tos == $past(tos)) || (tos == PW'($past(tos) + 1'b1))); // R9
  AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!rec_en && !pend) |=> $stable(tos)); // R1
  AST_DEBUG_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_kind == 2'd3 && !pend) |=> $stable(tos)); // R3
  AST_PAIR_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && rec_en && ev_kind == 2'd0 && ev_pair && !pend) |=> pend); // R4
  AST_PEND_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> (!pend && tos == PW'($past(tos) + 1'b1))); // R12
  AST_SINGLE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && rec_en && ev_kind != 2'd0 && !pend) |=> !pend); // R2
endmodule

bind lbr_stack lbr_stack_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .rec_en(rec_en), .ev_valid(ev_valid),
  .ev_kind(ev_kind), .ev_pair(ev_pair), .pend(pend), .tos(tos));

// File: tb/lbr_stack_tb_top.sv
module lbr_stack_tb_top;
  localparam int DEPTH = 4;
  localparam int PW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic rec_en = 1'b0, ev_valid = 1'b0, ev_pair = 1'b0;
  logic [1:0] ev_kind = '0, ev_mode = '0;
  logic [63:0] ev_from = '0, ev_to = '0, ev2_from = '0, ev2_to = '0;
  logic [PW-1:0] tos, rd_idx = '0;
  logic [63:0] rd_from, rd_to;

  int total = 0, bad = 0;
  bit done = 0;

  logic [63:0] m_from [DEPTH];
  logic [63:0] m_to   [DEPTH];
  logic [PW-1:0] m_tos;
  bit m_pend;
  logic [63:0] m_pf, m_pt;

  always #10 clk = ~clk;

  lbr_stack #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .rec_en(rec_en), .ev_valid(ev_valid),
    .ev_kind(ev_kind), .ev_pair(ev_pair), .ev_mode(ev_mode),
    .ev_from(ev_from), .ev_to(ev_to), .ev2_from(ev2_from), .ev2_to(ev2_to),
    .tos(tos), .rd_idx(rd_idx), .rd_from(rd_from), .rd_to(rd_to));

  function automatic logic [63:0] exp_addr(input logic [63:0] a, input logic [1:0] m);
    if (m >= 2) return a;
    return {32'd0, a[31:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check(tos == m_tos, {tag, " tos"}, 64'(tos), 64'(m_tos));
    for (int i = 0; i < DEPTH; i++) begin
      rd_idx = PW'(i);
      #1;
      check(rd_from == m_from[i], {tag, " from R11"}, rd_from, m_from[i]);
      check(rd_to == m_to[i], {tag, " to R11"}, rd_to, m_to[i]);
    end
  endtask

  task automatic model_write(input logic [63:0] f, input logic [63:0] t);
    m_tos = m_tos + 1'b1;
    m_from[m_tos] = f;
    m_to[m_tos] = t;
  endtask

  // one clock cycle of stimulus, driven and sampled at the falling edge
  task automatic step(input bit v, input logic [1:0] k, input bit p, input logic [1:0] md,
                      input logic [63:0] f, input logic [63:0] t,
                      input logic [63:0] f2, input logic [63:0] t2);
    ev_valid = v; ev_kind = k; ev_pair = p; ev_mode = md;
    ev_from = f; ev_to = t; ev2_from = f2; ev2_to = t2;
    if (m_pend) begin
      model_write(m_pf, m_pt);
      m_pend = 0;
    end else if (v && rec_en && k != 2'd3) begin
      model_write(exp_addr(f, md), exp_addr(t, md));
      if (k == 2'd0 && p) begin
        m_pend = 1;
        m_pf = exp_addr(f2, md);
        m_pt = exp_addr(t2, md);
      end
    end
    @(negedge clk);
    ev_valid = 1'b0; ev_pair = 1'b0;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  function automatic logic [63:0] r64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [PW-1:0] t0;
    void'($urandom(32'h1234_5678));
    m_tos = '0; m_pend = 0;
    for (int i = 0; i < DEPTH; i++) begin m_from[i] = '0; m_to[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare_all("R10 reset");

    step(1, 0, 0, 2, 64'hAAAA_0000_0000_0010, 64'hAAAA_0000_0000_0020, 0, 0);
    compare_all("R1 disabled branch");

    rec_en = 1'b1;
    step(1, 3, 0, 2, 64'h1, 64'h2, 0, 0);
    compare_all("R3 debug exception");

    step(1, 0, 0, 2, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 0, 0);
    compare_all("R2 R8 branch long mode");
    step(1, 1, 0, 0, 64'hDEAD_BEEF_0000_1000, 64'hCAFE_F00D_0000_2000, 0, 0);
    compare_all("R2 R6 interrupt legacy");
    step(1, 2, 0, 1, 64'hFFFF_FFFF_1234_5678, 64'h8000_0000_9ABC_DEF0, 0, 0);
    compare_all("R2 R7 exception compat");

    t0 = tos;
    step(1, 0, 1, 3, 64'hA0A0_0000_0000_0100, 64'hA0A0_0000_0000_0200,
         64'hB0B0_0000_0000_0300, 64'hB0B0_0000_0000_0400);
    check(tos == PW'(t0 + 1), "R4 first record of pair", 64'(tos), 64'(PW'(t0 + 1)));
    idle();
    compare_all("R4 pair order");

    step(1, 1, 1, 2, 64'h10, 64'h20, 64'h30, 64'h40);
    compare_all("R4 pair flag on interrupt ignored");
    idle();
    compare_all("R4 single record only");

    step(1, 0, 1, 2, 64'h100, 64'h200, 64'h300, 64'h400);
    step(1, 1, 0, 2, 64'h500, 64'h600, 0, 0);
    compare_all("R5 strobe during pending dropped");

    step(1, 0, 1, 0, 64'hFFFF_0000_0000_0700, 64'hFFFF_0000_0000_0800,
         64'hFFFF_0000_0000_0900, 64'hFFFF_0000_0000_0A00);
    rec_en = 1'b0;
    idle();
    compare_all("R12 pending survives disable, legacy clip");
    rec_en = 1'b1;

    for (int i = 0; i < DEPTH + 2; i++)
      step(1, 0, 0, 2, 64'(i + 64'h9000), 64'(i + 64'h9100), 0, 0);
    compare_all("R9 wrap overwrites oldest");

    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 9) == 0) rec_en = ~rec_en;
      step($urandom_range(0, 3) != 0, 2'($urandom), $urandom_range(0, 2) == 0,
           2'($urandom), r64(), r64(), r64(), r64());
      if (n % 8 == 7) compare_all("R2 R4 R6 random");
    end
    idle();
    compare_all("R2 random final");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule